// File: doc/BRIEF.md
# Rate-Selectable Punctured Convolutional Encoder

This block is the forward error correction stage on the transmit side of a broadcast-style baseband. It takes packet bytes in fixed-length frames over a valid/ready stream and passes every bit through a constraint-length-7, rate-1/2 convolutional code. It then drops coded bits by a puncturing pattern, which raises the code rate to 2/3, 3/4, 5/6 or 7/8. The kept bits leave as I/Q bit pairs on a second valid/ready stream.

The code rate is a 3-bit control input. It is held in a register so that a whole frame is coded at one rate. All five puncturing paths are built side by side, and the active rate only selects between them, so a rate change needs no structural change. Status outputs show the active rate, an unsupported-code flag and a busy flag.

Top module: `punct_conv_enc`

## Requirements
- R1: Each input bit u yields X = u^d1^d2^d3^d6 and Y = u^d2^d3^d5^d6, where dk is the input bit taken k bits earlier (generators 171 and 133 octal). The history is zero after reset, moves by one per input bit and carries over from one frame into the next.
- R2: A byte is taken when in_valid_i and in_ready_o are both high, and its bits are coded MSB first. in_ready_o is high exactly when no bit of the previous byte is still waiting to be coded.
- R3: Rate codes are 0=1/2, 1=2/3, 2=3/4, 3=5/6 and 4=7/8. The keep masks, listed from phase 0 onward, are: 1/2 X=1 Y=1; 2/3 X=10 Y=11; 3/4 X=101 Y=110; 5/6 X=10101 Y=11010; 7/8 X=1000101 Y=1111010. The phase advances once per input bit, wraps after the pattern period and restarts at 0 at the start of every frame.
- R4: The kept bits form one serial sequence, earliest input bit first and X before Y for the same input bit. Consecutive bits of that sequence are paired: the first goes on out_i_o and the second on out_q_o.
- R5: A frame is FRAME_BYTES bytes (188 by default). out_last_o is high on the final pair of each frame and on no other pair. If a frame leaves an odd number of kept bits, its final pair carries the lone bit on I and 0 on Q.
- R6: The rate input is sampled only while no frame is in progress, so a frame uses the code present when its first byte is taken. rate_o shows the active code and, while idle, follows a new setting one cycle later. A change during a frame affects neither that frame nor rate_o.
- R7: Codes 5 to 7 select rate 1/2, give rate_o = 0 and set rate_err_o. rate_err_o clears when a legal code is latched.
- R8: While out_valid_o is high and out_ready_i is low, the pair and out_last_o hold steady. No pair is lost or repeated under any backpressure.
- R9: busy_o goes high in the cycle after a frame's first byte is taken. It stays high until the frame's final pair has been loaded into the output register.
- R10: After reset, out_valid_o=0, in_ready_o=1, busy_o=0, rate_o=0 and rate_err_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 3 | Requested rate code |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_ready_o | output | 1 | Block can take a byte |
| out_valid_o | output | 1 | Output pair valid |
| out_i_o | output | 1 | First coded bit of the pair |
| out_q_o | output | 1 | Second coded bit of the pair |
| out_last_o | output | 1 | Final pair of a frame |
| out_ready_i | input | 1 | Downstream takes the pair |
| rate_o | output | 3 | Active rate code |
| rate_err_o | output | 1 | Unsupported code was requested |
| busy_o | output | 1 | Frame in progress |

## Verification
The hardest case to reach is a frame end that leaves an odd number of kept bits while the output register is stalled. Only 5/6 and 7/8 do this at the default frame length, and the padded tail pair must come out of a separate flush step. The stimulus runs full-length frames at every rate while an LFSR holds out_ready_i low about a quarter of the time, so the tail is often blocked. It also changes the rate input in the middle of a frame and sends an illegal code. A bench reference model predicts every pair and compares each one in order.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int unsigned NUM_RATES = 5;
  localparam int unsigned RATE_W    = 3;
  localparam int unsigned PH_W      = 3;
  localparam int unsigned MASK_W    = 8;

  // masks are stored with phase 0 at bit 0
  function automatic logic [MASK_W-1:0] x_mask(int unsigned r);
    case (r)
      1:       x_mask = 8'b0000_0001;
      2:       x_mask = 8'b0000_0101;
      3:       x_mask = 8'b0001_0101;
      4:       x_mask = 8'b0101_0001;
      default: x_mask = 8'b0000_0001;
    endcase
  endfunction

  function automatic logic [MASK_W-1:0] y_mask(int unsigned r);
    case (r)
      1:       y_mask = 8'b0000_0011;
      2:       y_mask = 8'b0000_0011;
      3:       y_mask = 8'b0000_1011;
      4:       y_mask = 8'b0010_1111;
      default: y_mask = 8'b0000_0001;
    endcase
  endfunction

  function automatic int unsigned period_of(int unsigned r);
    case (r)
      1:       period_of = 2;
      2:       period_of = 3;
      3:       period_of = 5;
      4:       period_of = 7;
      default: period_of = 1;
    endcase
  endfunction
endpackage

// File: rtl/pce_rate_ctrl.sv
module pce_rate_ctrl
  import pce_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] sel_i,
  input  logic              hold_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              err_o
);
  logic legal;
  assign legal = (int'(sel_i) < NUM_RATES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_o <= '0;
      err_o  <= 1'b0;
    end else if (!hold_i) begin
      rate_o <= legal ? sel_i : '0;
      err_o  <= !legal;
    end
  end

  p_err_rate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rate_o == '0));
endmodule

// File: rtl/pce_conv.sv
module pce_conv #(
  parameter int unsigned K   = 7,
  parameter logic [K-1:0] G_X = 7'o171,
  parameter logic [K-1:0] G_Y = 7'o133
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic bit_i,
  output logic x_o,
  output logic y_o
);
  // sr_q[K-2] is the newest past bit
  logic [K-2:0] sr_q;
  logic [K-1:0] win;

  assign win = {bit_i, sr_q};
  assign x_o = ^(win & G_X);
  assign y_o = ^(win & G_Y);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sr_q <= '0;
    else if (step_i) sr_q <= {bit_i, sr_q[K-2:1]};
  end
endmodule

// File: rtl/pce_puncture.sv
module pce_puncture
  import pce_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              step_i,
  input  logic              last_i,
  output logic              kx_o,
  output logic              ky_o
);
  logic [PH_W-1:0] phase_q;
  logic [NUM_RATES-1:0] path_kx, path_ky;
  logic [PH_W-1:0] path_end [NUM_RATES];
  logic [PH_W-1:0] cur_end;

  for (genvar r = 0; r < NUM_RATES; r++) begin : g_path
    localparam logic [MASK_W-1:0] XM = x_mask(r);
    localparam logic [MASK_W-1:0] YM = y_mask(r);
    assign path_kx[r]  = XM[phase_q];
    assign path_ky[r]  = YM[phase_q];
    assign path_end[r] = PH_W'(period_of(r) - 1);
  end

  always_comb begin
    kx_o    = path_kx[0];
    ky_o    = path_ky[0];
    cur_end = path_end[0];
    for (int r = 1; r < NUM_RATES; r++) begin
      if (int'(rate_i) == r) begin
        kx_o    = path_kx[r];
        ky_o    = path_ky[r];
        cur_end = path_end[r];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else if (step_i) begin
      if (last_i || phase_q == cur_end) phase_q <= '0;
      else                              phase_q <= phase_q + 1'b1;
    end
  end

  p_phase_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= cur_end);
  p_keep_any_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (kx_o || ky_o));
endmodule

// File: rtl/pce_pair_pack.sv
module pce_pair_pack (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic last_i,
  input  logic kx_i,
  input  logic ky_i,
  input  logic x_i,
  input  logic y_i,
  output logic can_step_o,
  output logic tail_o,
  output logic out_valid_o,
  output logic out_i_o,
  output logic out_q_o,
  output logic out_last_o,
  input  logic out_ready_i
);
  logic half_q, half_bit_q, flush_q;
  logic [2:0] b;
  logic [1:0] n;
  logic free;

  assign free       = !out_valid_o || out_ready_i;
  assign can_step_o = free && !flush_q;
  assign tail_o     = flush_q;

  always_comb begin
    b = '0;
    n = '0;
    if (half_q) begin b[0] = half_bit_q; n = 2'd1; end
    if (kx_i)   begin b[n] = x_i;        n = n + 2'd1; end
    if (ky_i)   begin b[n] = y_i;        n = n + 2'd1; end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q      <= 1'b0;
      half_bit_q  <= 1'b0;
      flush_q     <= 1'b0;
      out_valid_o <= 1'b0;
      out_i_o     <= 1'b0;
      out_q_o     <= 1'b0;
      out_last_o  <= 1'b0;
    end else if (step_i) begin
      if (n >= 2'd2) begin
        out_valid_o <= 1'b1;
        out_i_o     <= b[0];
        out_q_o     <= b[1];
        out_last_o  <= last_i && (n == 2'd2);
        half_q      <= (n == 2'd3);
        half_bit_q  <= b[2];
        flush_q     <= last_i && (n == 2'd3);
      end else begin
        half_q      <= n[0];
        half_bit_q  <= b[0];
        flush_q     <= last_i && n[0];
        if (out_ready_i) out_valid_o <= 1'b0;
      end
    end else if (flush_q && free) begin
      out_valid_o <= 1'b1;
      out_i_o     <= half_bit_q;
      out_q_o     <= 1'b0;
      out_last_o  <= 1'b1;
      half_q      <= 1'b0;
      flush_q     <= 1'b0;
    end else if (out_ready_i) begin
      out_valid_o <= 1'b0;
    end
  end

  p_hold_pair_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_i_o) && $stable(out_q_o) && $stable(out_last_o)));
  p_flush_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |-> half_q);
endmodule

// File: rtl/punct_conv_enc.sv
module punct_conv_enc
  import pce_pkg::*;
#(
  parameter int unsigned FRAME_BYTES = 188,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              in_valid_i,
  input  logic [BYTE_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic              out_i_o,
  output logic              out_q_o,
  output logic              out_last_o,
  input  logic              out_ready_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              rate_err_o,
  output logic              busy_o
);
  localparam int unsigned CNT_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
  localparam int unsigned BL_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BYTES - 1);

  logic [BYTE_W-1:0] byte_q;
  logic [BL_W-1:0]   bits_left_q;
  logic [CNT_W-1:0]  byte_cnt_q;
  logic last_byte_q, in_frame_q;
  logic accept, step, last_bit, can_step, tail;
  logic x, y, kx, ky;

  assign in_ready_o = (bits_left_q == '0);
  assign accept     = in_valid_i && in_ready_o;
  assign step       = (bits_left_q != '0) && can_step;
  assign last_bit   = last_byte_q && (bits_left_q == BL_W'(1));
  assign busy_o     = in_frame_q || tail;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q      <= '0;
      bits_left_q <= '0;
      byte_cnt_q  <= '0;
      last_byte_q <= 1'b0;
      in_frame_q  <= 1'b0;
    end else if (accept) begin
      byte_q      <= in_data_i;
      bits_left_q <= BL_W'(BYTE_W);
      last_byte_q <= (byte_cnt_q == LAST_IDX);
      byte_cnt_q  <= (byte_cnt_q == LAST_IDX) ? '0 : byte_cnt_q + 1'b1;
      in_frame_q  <= 1'b1;
    end else if (step) begin
      byte_q      <= byte_q << 1;
      bits_left_q <= bits_left_q - 1'b1;
      if (last_bit) in_frame_q <= 1'b0;
    end
  end

  pce_rate_ctrl u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (rate_sel_i),
    .hold_i (in_frame_q),
    .rate_o (rate_o),
    .err_o  (rate_err_o)
  );

  pce_conv u_conv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .bit_i  (byte_q[BYTE_W-1]),
    .x_o    (x),
    .y_o    (y)
  );

  pce_puncture u_punct (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rate_i (rate_o),
    .step_i (step),
    .last_i (last_bit),
    .kx_o   (kx),
    .ky_o   (ky)
  );

  pce_pair_pack u_pack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .last_i      (last_bit),
    .kx_i        (kx),
    .ky_i        (ky),
    .x_i         (x),
    .y_i         (y),
    .can_step_o  (can_step),
    .tail_o      (tail),
    .out_valid_o (out_valid_o),
    .out_i_o     (out_i_o),
    .out_q_o     (out_q_o),
    .out_last_o  (out_last_o),
    .out_ready_i (out_ready_i)
  );

  p_rate_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_frame_q |=> $stable(rate_o));
  p_busy_on_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> busy_o);
endmodule

// File: tb/punct_conv_enc_tb_top.sv
module punct_conv_enc_tb_top;
  localparam int FB = 188;

  logic clk = 1'b0;
  logic rst_ni;
  logic [2:0] rate_sel_i;
  logic in_valid_i;
  logic [7:0] in_data_i;
  logic in_ready_o, out_valid_o, out_i_o, out_q_o, out_last_o;
  logic out_ready_i;
  logic [2:0] rate_o;
  logic rate_err_o, busy_o;

  always #4 clk = ~clk;

  punct_conv_enc #(.FRAME_BYTES(FB)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .rate_sel_i(rate_sel_i),
    .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
    .out_valid_o(out_valid_o), .out_i_o(out_i_o), .out_q_o(out_q_o),
    .out_last_o(out_last_o), .out_ready_i(out_ready_i),
    .rate_o(rate_o), .rate_err_o(rate_err_o), .busy_o(busy_o)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit rst_done = 0;
  bit bp_mode = 0;
  logic [15:0] lf = 16'hACE1;
  logic [2:0] exp_q[$];
  string tag_q[$];
  logic [5:0] m_sr = '0;

  int    per_t[5] = '{1, 2, 3, 5, 7};
  string xs[5] = '{"1", "10", "101", "10101", "1000101"};
  string ys[5] = '{"1", "11", "110", "11010", "1111010"};

  task automatic chk(bit ok, string msg, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  // scoreboard monitor and backpressure
  always @(negedge clk) begin
    logic [2:0] e;
    string t;
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    out_ready_i = (rst_done && bp_mode) ? (lf[1:0] != 2'b00) : 1'b1;
    if (rst_done && out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8 unexpected extra pair", 1, 0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({out_i_o, out_q_o, out_last_o} == e, t,
            int'({out_i_o, out_q_o, out_last_o}), int'(e));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      failures++;
      $display("FAIL watchdog expired, R8 output stalled");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] gen_byte(int seed, int idx);
    logic [7:0] v;
    v = 8'(seed * 53 + idx * 29 + (idx >> 2) * 7);
    return v ^ 8'(idx * idx);
  endfunction

  task automatic send_byte(logic [7:0] d);
    bit rdy;
    in_valid_i = 1'b1;
    in_data_i  = d;
    forever begin
      #1 rdy = in_ready_o;
      @(negedge clk);
      if (rdy) break;
    end
    in_valid_i = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while ((exp_q.size() != 0 || busy_o || out_valid_o) && guard < 20000);
    chk(exp_q.size() == 0, "R5 all pairs of frame delivered", exp_q.size(), 0);
    chk(busy_o == 1'b0, "R9 busy low after frame", int'(busy_o), 0);
  endtask

  task automatic send_frame(int code, int seed, int chg_at, int new_code, string tag);
    int eff;
    int ph;
    logic bits[$];
    logic u, x, y;
    logic [7:0] d;
    eff = (code > 4) ? 0 : code;
    ph = 0;
    for (int b = 0; b < FB; b++) begin
      d = gen_byte(seed, b);
      for (int k = 7; k >= 0; k--) begin
        u = d[k];
        x = u ^ m_sr[0] ^ m_sr[1] ^ m_sr[2] ^ m_sr[5];
        y = u ^ m_sr[1] ^ m_sr[2] ^ m_sr[4] ^ m_sr[5];
        m_sr = {m_sr[4:0], u};
        if (xs[eff][ph] == 8'h31) bits.push_back(x);
        if (ys[eff][ph] == 8'h31) bits.push_back(y);
        ph = (ph + 1 == per_t[eff]) ? 0 : ph + 1;
      end
    end
    if (bits.size() % 2 != 0) bits.push_back(1'b0);
    for (int p = 0; p < bits.size(); p += 2) begin
      exp_q.push_back({bits[p], bits[p+1], (p + 2 == bits.size())});
      tag_q.push_back($sformatf("R1 R2 R3 R4 R5 R8 %s pair %0d", tag, p / 2));
    end
    rate_sel_i = 3'(code);
    for (int b = 0; b < FB; b++) begin
      send_byte(gen_byte(seed, b));
      if (b == 0) begin
        chk(busy_o == 1'b1, "R9 busy after first byte", int'(busy_o), 1);
        chk(int'(rate_o) == eff, "R6 active rate at frame start", int'(rate_o), eff);
        chk(rate_err_o == (code > 4), "R7 error flag", int'(rate_err_o), int'(code > 4));
      end
      if (b == chg_at) rate_sel_i = 3'(new_code);
      if (chg_at >= 0 && b == chg_at + 3)
        chk(int'(rate_o) == eff, "R6 rate frozen mid-frame", int'(rate_o), eff);
    end
    wait_idle();
  endtask

  initial begin
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    in_data_i = '0;
    rate_sel_i = '0;
    repeat (3) @(negedge clk);
    chk(out_valid_o == 1'b0, "R10 out_valid in reset", int'(out_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    rst_done = 1;
    chk(out_valid_o == 1'b0, "R10 out_valid after reset", int'(out_valid_o), 0);
    chk(in_ready_o == 1'b1, "R10 in_ready after reset", int'(in_ready_o), 1);
    chk(busy_o == 1'b0, "R10 busy after reset", int'(busy_o), 0);
    chk(rate_o == 3'd0, "R10 rate after reset", int'(rate_o), 0);
    chk(rate_err_o == 1'b0, "R10 err after reset", int'(rate_err_o), 0);

    send_frame(0, 1, -1, 0, "rate1/2");
    bp_mode = 1;
    send_frame(1, 2, -1, 0, "rate2/3");
    send_frame(2, 3, -1, 0, "rate3/4");
    send_frame(3, 4, -1, 0, "rate5/6");
    send_frame(4, 5, -1, 0, "rate7/8");
    send_frame(6, 6, -1, 0, "R7 illegal code");
    send_frame(3, 7, -1, 0, "R7 legal after illegal");
    send_frame(2, 8, 20, 4, "R6 change mid-frame");
    @(negedge clk);
    chk(rate_o == 3'd4, "R6 new rate latched when idle", int'(rate_o), 4);
    rate_sel_i = 3'd1;
    @(negedge clk);
    chk(rate_o == 3'd1, "R6 idle update one cycle later", int'(rate_o), 1);
    send_frame(1, 9, -1, 0, "rate2/3 after change");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule